// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds, for up to four processors, one pending inter-processor interrupt (IPI) bit and one pending interval-timer bit each. Every processor has its own IPI output and timer output. These outputs are the pending bits themselves. A periodic tick input raises the timer interrupt on every processor that is present. Software uses a 64-bit register port to raise and drop interrupts. It can write to a combined command register that carries three separate processor masks in three nibbles. It can also write to three dedicated registers, each of which takes a single mask in bits 3:0.

A configuration input gives the number of processors present. Mask bits for absent processors have no effect. Two kinds of access are flagged with a one-cycle pulse. Redundant operations, such as raising an IPI that is already pending or dropping one that is not, pulse a warning output. Commands that select no processor at all pulse an error output. A read of the combined register returns the requester's processor number and both pending vectors.

Top module: `ipi_timer_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit is zero, and `warn_o` and `err_o` are low.
- R2: A write to the combined register (select 0) raises the IPI of each processor set in bits 15:12. The new state shows on `ipi_o` in the first cycle after the write edge.
- R3: In a combined-register write, bits 11:8 drop IPIs and bits 7:4 drop timer interrupts. Within one write, the IPI raise is applied first and the IPI drop second, so a processor named in both fields ends up clear.
- R4: A combined-register write is flagged as an error when bits 15:12, 11:8 and 7:4 are all zero and bit 28 is also zero. Bit 28 alone is an acknowledge: it is accepted and changes nothing. The error shows as an `err_o` pulse one cycle after the write, and state does not change.
- R5: A warning shows as a `warn_o` pulse one cycle after the write, and the affected bit keeps its value. It is raised when a write raises an IPI that is already pending, or drops an IPI that is not pending after the raise step. Dropping a timer bit that is not pending raises no warning.
- R6: Each cycle with `tick_i` high sets the timer bit of every present processor. Bits that are already set stay set.
- R7: The dedicated registers act on mask bits 3:0 of the write data. Select 1 raises IPIs, select 2 drops IPIs and select 3 drops timer interrupts. A zero mask produces an `err_o` pulse. Data bits above 3 are ignored.
- R8: `num_cpu_i` gives the processor count. A value of 0 acts as 1, and values above 4 act as 4. Mask bits for processors at or above the count change nothing and raise no warning.
- R9: While `reg_rd_i` is high with select 0, `reg_rdata_o` carries `req_cpu_i` in bits 1:0, the timer vector in bits 7:4 and the IPI vector in bits 11:8, with every other bit zero. The data shows the state in the same cycle. In all other cases `reg_rdata_o` is zero.
- R10: If a tick and a timer-drop write for the same present processor land in the same cycle, the timer bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Periodic timer tick |
| num_cpu_i | input | 3 | Number of processors present |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select: 0 combined, 1 IPI raise, 2 IPI drop, 3 timer drop |
| reg_wdata_i | input | 64 | Write data |
| req_cpu_i | input | 2 | Number of the processor making the access |
| reg_rdata_o | output | 64 | Read data |
| ipi_o | output | 4 | IPI pending per processor |
| tmr_o | output | 4 | Timer interrupt pending per processor |
| warn_o | output | 1 | Redundant raise or drop pulse |
| err_o | output | 1 | Empty-command pulse |

## Verification
The pending vectors and both flag pulses are registered at the edge that takes the write or tick. They are therefore due one cycle after the stimulus. Read data is combinational and reflects the state before that edge. For each step, the bench drives inputs on a falling edge. A short delay later, still before the rising edge, it compares `reg_rdata_o` with its model of the current state. It then waits for the next falling edge and compares `ipi_o`, `tmr_o`, `warn_o` and `err_o` with the next state, which it computes from the requirements.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int NCPU   = 4;
    localparam int DW     = 64;
    localparam int CNT_W  = $clog2(NCPU) + 1;
    localparam int CPU_W  = $clog2(NCPU);

    // field positions inside the combined command register
    localparam int F_IPI_SET = 12;
    localparam int F_IPI_CLR = 8;
    localparam int F_TMR_CLR = 4;
    localparam int F_ACK     = 28;

    // read-back field positions
    localparam int RD_TMR = 4;
    localparam int RD_IPI = 8;

    typedef enum logic [1:0] {
        SEL_COMBINED = 2'd0,
        SEL_IPI_SET  = 2'd1,
        SEL_IPI_CLR  = 2'd2,
        SEL_TMR_CLR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NCPU-1:0] ipi_set;
        logic [NCPU-1:0] ipi_clr;
        logic [NCPU-1:0] tmr_clr;
        logic            err;
    } cmd_t;

    function automatic logic [NCPU-1:0] present_mask(input logic [CNT_W-1:0] n);
        int eff;
        logic [NCPU-1:0] m;
        eff = int'(n);
        if (eff == 0)   eff = 1;
        if (eff > NCPU) eff = NCPU;
        for (int i = 0; i < NCPU; i++) m[i] = (i < eff);
        return m;
    endfunction

endpackage

// File: rtl/ipt_cmd_decode.sv
module ipt_cmd_decode
    import ipt_pkg::*;
#(
    parameter int DATA_W = ipt_pkg::DW
) (
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NCPU-1:0]   present_i,
    output cmd_t              cmd_o
);
    logic [NCPU-1:0] f_set, f_clr, f_tclr, f_mask;

    assign f_set  = wdata_i[F_IPI_SET +: NCPU];
    assign f_clr  = wdata_i[F_IPI_CLR +: NCPU];
    assign f_tclr = wdata_i[F_TMR_CLR +: NCPU];
    assign f_mask = wdata_i[0 +: NCPU];

    always_comb begin
        cmd_o = '0;
        if (wr_i) begin
            unique case (sel_i)
                SEL_COMBINED: begin
                    cmd_o.ipi_set = f_set  & present_i;
                    cmd_o.ipi_clr = f_clr  & present_i;
                    cmd_o.tmr_clr = f_tclr & present_i;
                    cmd_o.err     = (f_set == '0) && (f_clr == '0) &&
                                    (f_tclr == '0) && !wdata_i[F_ACK];
                end
                SEL_IPI_SET: begin
                    cmd_o.ipi_set = f_mask & present_i;
                    cmd_o.err     = (f_mask == '0);
                end
                SEL_IPI_CLR: begin
                    cmd_o.ipi_clr = f_mask & present_i;
                    cmd_o.err     = (f_mask == '0);
                end
                SEL_TMR_CLR: begin
                    cmd_o.tmr_clr = f_mask & present_i;
                    cmd_o.err     = (f_mask == '0);
                end
                default: cmd_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/ipt_pend_bank.sv
module ipt_pend_bank #(
    parameter int N        = 4,
    parameter bit SET_WINS = 1'b0,
    parameter bit WARN_EN  = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic         warn_o
);
    logic [N-1:0] pend_q, pend_d, set_only;
    logic         warn_d, warn_q, past_ok;

    generate
        if (SET_WINS) begin : g_set_wins
            assign pend_d   = (pend_q & ~clr_i) | set_i;
            assign set_only = set_i;
        end else begin : g_clr_last
            logic [N-1:0] after_set;
            assign after_set = pend_q | set_i;
            assign pend_d    = after_set & ~clr_i;
            assign set_only  = set_i & ~clr_i;
        end
        if (WARN_EN) begin : g_warn
            assign warn_d = (|(set_i & pend_q)) | (|(clr_i & ~(pend_q | set_i)));
        end else begin : g_nowarn
            assign warn_d = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            warn_q  <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            pend_q  <= pend_d;
            warn_q  <= warn_d;
            past_ok <= 1'b1;
        end
    end

    assign pend_o = pend_q;
    assign warn_o = warn_q;

    // R2 / R6 / R10: a set request not overridden lands in the next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((pend_q & $past(set_only)) == $past(set_only)));

    // R3: a clear without a competing set leaves the bit low
    a_r3_clr_lands: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((pend_q & $past(clr_i & ~set_i)) == '0));

    // R5: bits with no request keep their value
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((pend_q ^ $past(pend_q)) & ~$past(set_i | clr_i)) == '0);
endmodule

// File: rtl/ipt_readback.sv
module ipt_readback
    import ipt_pkg::*;
#(
    parameter int DATA_W = ipt_pkg::DW
) (
    input  logic              rd_i,
    input  reg_sel_e          sel_i,
    input  logic [CPU_W-1:0]  req_cpu_i,
    input  logic [NCPU-1:0]   ipi_i,
    input  logic [NCPU-1:0]   tmr_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (rd_i && sel_i == SEL_COMBINED) begin
            rdata_o[0 +: CPU_W]   = req_cpu_i;
            rdata_o[RD_TMR +: NCPU] = tmr_i;
            rdata_o[RD_IPI +: NCPU] = ipi_i;
        end
    end
endmodule

// File: rtl/ipi_timer_ctrl.sv
module ipi_timer_ctrl
    import ipt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic [CNT_W-1:0]     num_cpu_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [1:0]           reg_sel_i,
    input  logic [DW-1:0]        reg_wdata_i,
    input  logic [CPU_W-1:0]     req_cpu_i,
    output logic [DW-1:0]        reg_rdata_o,
    output logic [NCPU-1:0]      ipi_o,
    output logic [NCPU-1:0]      tmr_o,
    output logic                 warn_o,
    output logic                 err_o
);
    reg_sel_e        sel;
    logic [NCPU-1:0] present, tick_mask;
    cmd_t            cmd;
    logic            ipi_warn, tmr_warn, err_q, past_ok;

    assign sel       = reg_sel_e'(reg_sel_i);
    assign present   = present_mask(num_cpu_i);
    assign tick_mask = tick_i ? present : '0;

    ipt_cmd_decode #(.DATA_W(DW)) u_dec (
        .wr_i(reg_wr_i), .sel_i(sel), .wdata_i(reg_wdata_i),
        .present_i(present), .cmd_o(cmd)
    );

    ipt_pend_bank #(.N(NCPU), .SET_WINS(1'b0), .WARN_EN(1'b1)) u_ipi (
        .clk(clk), .rst(rst), .set_i(cmd.ipi_set), .clr_i(cmd.ipi_clr),
        .pend_o(ipi_o), .warn_o(ipi_warn)
    );

    ipt_pend_bank #(.N(NCPU), .SET_WINS(1'b1), .WARN_EN(1'b0)) u_tmr (
        .clk(clk), .rst(rst), .set_i(tick_mask), .clr_i(cmd.tmr_clr),
        .pend_o(tmr_o), .warn_o(tmr_warn)
    );

    ipt_readback #(.DATA_W(DW)) u_rd (
        .rd_i(reg_rd_i), .sel_i(sel), .req_cpu_i(req_cpu_i),
        .ipi_i(ipi_o), .tmr_i(tmr_o), .rdata_o(reg_rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            err_q   <= cmd.err;
            past_ok <= 1'b1;
        end
    end

    assign err_o  = err_q;
    assign warn_o = ipi_warn | tmr_warn;

    // R8: no pending bit rises for a processor outside the present set
    a_r8_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (((ipi_o | tmr_o) & ~$past(ipi_o | tmr_o) & ~$past(present)) == '0));

    // R6: a tick leaves every present timer bit set
    a_r6_tick_all: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(tick_i) |-> ((tmr_o & $past(present)) == $past(present)));

    // R4: an empty combined command is flagged
    a_r4_empty_err: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(reg_wr_i && reg_sel_i == 2'd0 &&
                         reg_wdata_i[15:4] == 12'h0 && !reg_wdata_i[28]) |-> err_o);

    // R9: combined read-back carries the live IPI vector
    a_r9_read_ipi: assert property (@(posedge clk) disable iff (rst)
        reg_rd_i && reg_sel_i == 2'd0 |-> reg_rdata_o[11:8] == ipi_o);

    // R1: flags are idle right after reset
    a_r1_flags_idle: assert property (@(posedge clk) disable iff (rst)
        !past_ok |-> !warn_o && !err_o);
endmodule

// File: tb/ipi_timer_ctrl_bench.sv
module ipi_timer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [2:0]  ncpu;
    logic        wr, rd;
    logic [1:0]  sel;
    logic [63:0] wdata;
    logic [1:0]  cpu;
    logic [63:0] rdata;
    logic [3:0]  ipi, tmr;
    logic        warn, err;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_ipi, m_tmr;

    always #2 clk = ~clk;

    ipi_timer_ctrl u_ipi_timer_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick), .num_cpu_i(ncpu),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .req_cpu_i(cpu), .reg_rdata_o(rdata), .ipi_o(ipi), .tmr_o(tmr),
        .warn_o(warn), .err_o(err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pmask(input logic [2:0] n);
        int e;
        logic [3:0] m;
        e = (n == 0) ? 1 : ((n > 4) ? 4 : int'(n));
        for (int i = 0; i < 4; i++) m[i] = (i < e);
        return m;
    endfunction

    // one cycle: drive at falling edge, check read now, check state next falling edge
    task automatic step(input string tag, input logic t, input logic w,
                        input logic [1:0] s, input logic [63:0] d,
                        input logic r, input logic [1:0] c);
        logic [3:0] pm, rs, rc, tc, mid, n_ipi, n_tmr;
        logic       e_warn, e_err;
        tick = t; wr = w; sel = s; wdata = d; rd = r; cpu = c;
        #1;
        chk({tag, "/R9"}, "rdata", rdata,
            (r && s == 2'd0) ? {52'h0, m_ipi, m_tmr, 2'b00, c} : 64'h0);
        pm = pmask(ncpu);
        rs = '0; rc = '0; tc = '0; e_err = 1'b0;
        if (w) begin
            case (s)
                2'd0: begin
                    rs = d[15:12]; rc = d[11:8]; tc = d[7:4];
                    e_err = (d[15:4] == 12'h0) && !d[28];
                end
                2'd1: begin rs = d[3:0]; e_err = (d[3:0] == 4'h0); end
                2'd2: begin rc = d[3:0]; e_err = (d[3:0] == 4'h0); end
                default: begin tc = d[3:0]; e_err = (d[3:0] == 4'h0); end
            endcase
        end
        rs &= pm; rc &= pm; tc &= pm;
        mid    = m_ipi | rs;
        e_warn = (|(rs & m_ipi)) | (|(rc & ~mid));
        n_ipi  = mid & ~rc;
        n_tmr  = (m_tmr & ~tc) | (t ? pm : 4'h0);
        @(posedge clk);
        @(negedge clk);
        m_ipi = n_ipi;
        m_tmr = n_tmr;
        chk({tag, "/R2"}, "ipi_o", {60'h0, ipi}, {60'h0, m_ipi});
        chk({tag, "/R6"}, "tmr_o", {60'h0, tmr}, {60'h0, m_tmr});
        chk({tag, "/R5"}, "warn_o", {63'h0, warn}, {63'h0, e_warn});
        chk({tag, "/R4"}, "err_o", {63'h0, err}, {63'h0, e_err});
        tick = 0; wr = 0; rd = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; tick = 0; wr = 0; rd = 0; sel = 0; wdata = 0; cpu = 0; ncpu = 3'd4;
        m_ipi = 0; m_tmr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "ipi_o", {60'h0, ipi}, 64'h0);
        chk("R1", "tmr_o", {60'h0, tmr}, 64'h0);
        chk("R1", "warn_o", {63'h0, warn}, 64'h0);
        chk("R1", "err_o", {63'h0, err}, 64'h0);
        // R2: raise IPI to cpu0 and cpu2 through the combined register
        step("R2", 0, 1, 2'd0, 64'h5000, 1, 2'd1);
        // R5: raise again -> warning
        step("R5", 0, 1, 2'd0, 64'h1000, 1, 2'd2);
        // R3: raise and drop same cpu in one write, drop cpu2
        step("R3", 0, 1, 2'd0, 64'h2600, 1, 2'd3);
        // R5: drop IPI that is not pending
        step("R5", 0, 1, 2'd2, 64'h8, 1, 2'd0);
        // R6: tick raises timer for all present
        step("R6", 1, 0, 2'd0, 64'h0, 1, 2'd0);
        // R10: tick and timer drop together
        step("R10", 1, 1, 2'd0, 64'h00F0, 1, 2'd1);
        // R3: drop timer via combined register
        step("R3", 0, 1, 2'd0, 64'h0030, 1, 2'd1);
        // R4: acknowledge only, and empty command
        step("R4", 0, 1, 2'd0, 64'h1000_0000, 1, 2'd0);
        step("R4", 0, 1, 2'd0, 64'hFFFF_0000_0000_000F, 1, 2'd0);
        // R7: dedicated registers, upper data ignored, zero mask error
        step("R7", 0, 1, 2'd1, 64'hFFFF_0000_0000_0006, 1, 2'd0);
        step("R7", 0, 1, 2'd2, 64'h0000_0000_0000_0004, 1, 2'd0);
        step("R7", 0, 1, 2'd3, 64'h0000_0000_0000_000C, 1, 2'd0);
        step("R7", 0, 1, 2'd1, 64'h0000_0000_0000_00F0, 1, 2'd0);
        // R8: only two processors present
        ncpu = 3'd2;
        step("R8", 0, 1, 2'd1, 64'hC, 1, 2'd0);
        step("R8", 1, 1, 2'd0, 64'h3000, 1, 2'd0);
        ncpu = 3'd0;
        step("R8", 1, 1, 2'd2, 64'hE, 1, 2'd1);
        ncpu = 3'd7;
        step("R8", 1, 0, 2'd0, 64'h0, 1, 2'd2);
        // R9: reads on other selects return zero
        step("R9", 0, 0, 2'd2, 64'h0, 1, 2'd3);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [63:0] d;
            if ((k % 97) == 0) ncpu = 3'($urandom_range(0, 7));
            d = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) d[15:4] = 12'h0;
            if ($urandom_range(0, 1) == 0) d[28] = 1'b0;
            step("RND", ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
                 2'($urandom_range(0, 3)), d, ($urandom_range(0, 1) == 1),
                 2'($urandom_range(0, 3)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule